// File: doc/BRIEF.md
# ADC Channel Readback Target

This block is the target side of a two-phase I2C transaction that fetches one sample from an eleven-channel monitoring converter. A host first writes a single pointer byte that names the channel. When the host then turns the bus around and addresses the block for reading, the block refuses that read with a NACK. The refusal itself starts a conversion of fixed length. Once the conversion time has elapsed, a fresh two-byte read returns a 16-bit word that holds the sample and, for the host to check, the channel number it belongs to.

The block answers at a single 7-bit address derived from a base address input. Bits 6:3 of the base are replaced by the pattern 1001, so the address is `(base & 0x78')` with those bits forced, that is `(base_addr_i & ~7'h78) | 7'h48`. Samples for all channels arrive on a flat parallel port, 10 bits per channel. The channel at index n occupies bits `n*10+9 : n*10`. The bus pins are modelled as plain inputs together with an open-drain pull-down enable.

The conversion time is `CLK_MHZ * CONV_US` system clocks. The default is 70 µs. A slower device variant uses 185 µs.

Top module: `adc_rdbk_resp`

## Requirements
- R1: The block acknowledges only address `(base_addr_i & ~7'h78) | 7'h48`. It leaves any other address un-acknowledged and ignores the rest of that transaction.
- R2: In a write to the block, the address byte (R/W bit 0) is ACKed. A following pointer byte of value n<<3 with n in 0..10 is ACKed and selects channel n.
- R3: A pointer byte whose bits 2:0 are non-zero, or whose bits 7:3 exceed 10, is ACKed but leaves no channel selected. Every read is then NACKed until a valid pointer is written.
- R4: The first read addressed to the block after a valid pointer write is NACKed. That NACK starts a conversion lasting exactly `CLK_MHZ*CONV_US` clock cycles.
- R5: A read during the conversion is NACKed and keeps the selected channel. A read after the conversion ends is ACKed and returns that channel.
- R6: An ACKed read sends the high byte first, then the low byte. The word is `{1'b0, channel[3:0], 1'b0, sample[9:0]}`, where the sample is the selected channel's input captured in the cycle the conversion ends.
- R7: The result stays constant and readable for repeated reads, even if the sample inputs change. A new pointer write discards it.
- R8: The block drives SDA low only for its ACK bits and for 0 data bits. `sda_oe_o` is 0 in reset, after a stop, and after the host's acknowledge of the low byte.
- R9: Bytes that follow the pointer byte within the same write transaction are NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| base_addr_i | input | 7 | Configured base device address |
| sample_i | input | 110 | Channel samples, 10 bits each, channel n at bits n*10 +: 10 |

## Verification
Random channels and random sample vectors are run through the full sequence of arm, early read, wait and read. This separates the correct selection of channel and sample from errors in tag placement or byte order. Directed cases cover the following:
- channels 0 and 10 at the ends of the range;
- pointers that are mis-aligned and out of range, which tell "ignored" apart from "clamped";
- a foreign address, and a change of base address;
- a stray byte after the pointer;
- sample inputs that change after the conversion, which show whether capture happens at the end of conversion or at read time.

// File: rtl/adc_rdbk_pkg.sv
package adc_rdbk_pkg;
  localparam int unsigned N_CH   = 11;
  localparam int unsigned S_W    = 10;
  localparam int unsigned CH_W   = 4;
  localparam int unsigned WORD_W = 2 + CH_W + S_W;
  localparam logic [6:0]  ADDR_MASK = 7'h78;
  localparam logic [6:0]  ADDR_FORCE = 7'h48;

  typedef enum logic [2:0] {
    T_IDLE, T_ADDR, T_AACK, T_PTR, T_PACK, T_TX, T_TACK, T_SKIP
  } tgt_st_e;

  typedef enum logic [1:0] {
    P_NONE, P_ARMED, P_BUSY, P_READY
  } ptr_st_e;
endpackage

// File: rtl/bus_cond.sv
module bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  // bit 1 = current synced level, bit 2 = previous
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  assign sda_o      = sda_q[1];
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import adc_rdbk_pkg::*;
#(
  parameter int unsigned WW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  input  logic [6:0]    own_addr_i,
  input  logic          rd_ok_i,
  input  logic [WW-1:0] tx_word_i,
  output logic          sda_oe_o,
  output logic          ptr_we_o,
  output logic [7:0]    ptr_byte_o,
  output logic          rd_req_o
);
  tgt_st_e    st;
  logic [3:0] cnt;
  logic [7:0] sh, tx_sh;
  logic       ack_q, to_tx, lo_sel, more;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= T_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx_sh    <= '0;
      ack_q    <= 1'b0;
      to_tx    <= 1'b0;
      lo_sel   <= 1'b0;
      more     <= 1'b0;
      ptr_we_o <= 1'b0;
      rd_req_o <= 1'b0;
    end else begin
      ptr_we_o <= 1'b0;
      rd_req_o <= 1'b0;
      if (start_i) begin
        st    <= T_ADDR;
        cnt   <= '0;
        ack_q <= 1'b0;
      end else if (stop_i) begin
        st    <= T_IDLE;
        ack_q <= 1'b0;
      end else begin
        unique case (st)
          T_ADDR, T_PTR: begin
            if (scl_rise_i) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end
            if (scl_fall_i && cnt == 4'd8) begin
              if (st == T_PTR) begin
                ack_q    <= 1'b1;
                ptr_we_o <= 1'b1;
                st       <= T_PACK;
              end else if (sh[7:1] != own_addr_i) begin
                st <= T_SKIP;
              end else if (!sh[0]) begin
                ack_q <= 1'b1;
                to_tx <= 1'b0;
                st    <= T_AACK;
              end else begin
                rd_req_o <= 1'b1;
                if (rd_ok_i) begin
                  ack_q <= 1'b1;
                  to_tx <= 1'b1;
                  st    <= T_AACK;
                end else begin
                  st <= T_SKIP;
                end
              end
            end
          end
          T_AACK: if (scl_fall_i) begin
            ack_q <= 1'b0;
            cnt   <= '0;
            if (to_tx) begin
              tx_sh  <= tx_word_i[WW-1 -: 8];
              lo_sel <= 1'b0;
              st     <= T_TX;
            end else begin
              st <= T_PTR;
            end
          end
          T_PACK: if (scl_fall_i) begin
            ack_q <= 1'b0;
            st    <= T_SKIP;
          end
          T_TX: begin
            if (scl_rise_i) cnt <= cnt + 4'd1;
            if (scl_fall_i) begin
              if (cnt == 4'd8) st <= T_TACK;
              else tx_sh <= {tx_sh[6:0], 1'b0};
            end
          end
          T_TACK: begin
            if (scl_rise_i) more <= ~sda_i & ~lo_sel;
            if (scl_fall_i) begin
              if (more) begin
                tx_sh  <= tx_word_i[7:0];
                lo_sel <= 1'b1;
                cnt    <= '0;
                st     <= T_TX;
              end else begin
                st <= T_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_byte_o = sh;
  assign sda_oe_o   = ack_q | ((st == T_TX) & ~tx_sh[7]);
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int unsigned CONV_CYC = 14000,
  localparam int unsigned CW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic clr_i,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt;
  logic          last;

  assign last   = (cnt == CW'(CONV_CYC - 1));
  assign done_o = busy_o & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (clr_i) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (go_i) begin
      busy_o <= 1'b1;
      cnt    <= '0;
    end else if (busy_o) begin
      if (last) busy_o <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rdbk_ctrl.sv
module rdbk_ctrl
  import adc_rdbk_pkg::*;
#(
  parameter int unsigned NC = N_CH,
  parameter int unsigned SW = S_W,
  localparam int unsigned WW = 2 + CH_W + SW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_we_i,
  input  logic [7:0]       ptr_byte_i,
  input  logic             rd_req_i,
  input  logic             done_i,
  input  logic [NC*SW-1:0] sample_i,
  output logic             go_o,
  output logic             clr_o,
  output logic             rd_ok_o,
  output logic [CH_W-1:0]  ch_o,
  output logic [WW-1:0]    word_o
);
  ptr_st_e pst;
  logic    ptr_ok;

  assign ptr_ok  = (ptr_byte_i[2:0] == 3'b000) && (32'(ptr_byte_i[7:3]) < NC);
  assign go_o    = rd_req_i & (pst == P_ARMED);
  assign clr_o   = ptr_we_i;
  assign rd_ok_o = (pst == P_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pst    <= P_NONE;
      ch_o   <= '0;
      word_o <= '0;
    end else if (ptr_we_i) begin
      if (ptr_ok) begin
        pst  <= P_ARMED;
        ch_o <= ptr_byte_i[3 +: CH_W];
      end else begin
        pst <= P_NONE;
      end
    end else if (go_o) begin
      pst <= P_BUSY;
    end else if (done_i && pst == P_BUSY) begin
      pst    <= P_READY;
      word_o <= {1'b0, ch_o, 1'b0, sample_i[32'(ch_o)*SW +: SW]};
    end
  end
endmodule

// File: rtl/adc_rdbk_resp.sv
module adc_rdbk_resp
  import adc_rdbk_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 200,
  parameter int unsigned CONV_US = 70,
  localparam int unsigned CONV_CYC = CLK_MHZ * CONV_US
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [6:0]         base_addr_i,
  input  logic [N_CH*S_W-1:0] sample_i
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic ptr_we, rd_req, rd_ok, conv_go, conv_clr, conv_busy, conv_done;
  logic [7:0]        ptr_byte;
  logic [CH_W-1:0]   ptr_ch;
  logic [WORD_W-1:0] result;
  logic [6:0]        own_addr;

  assign own_addr = (base_addr_i & ~ADDR_MASK) | ADDR_FORCE;

  bus_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det), .sda_o(sda_s)
  );

  i2c_tgt #(.WW(WORD_W)) u_tgt (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .sda_i(sda_s),
    .own_addr_i(own_addr), .rd_ok_i(rd_ok), .tx_word_i(result),
    .sda_oe_o, .ptr_we_o(ptr_we), .ptr_byte_o(ptr_byte), .rd_req_o(rd_req)
  );

  rdbk_ctrl #(.NC(N_CH), .SW(S_W)) u_ctrl (
    .clk_i, .rst_ni,
    .ptr_we_i(ptr_we), .ptr_byte_i(ptr_byte), .rd_req_i(rd_req),
    .done_i(conv_done), .sample_i,
    .go_o(conv_go), .clr_o(conv_clr), .rd_ok_o(rd_ok),
    .ch_o(ptr_ch), .word_o(result)
  );

  conv_timer #(.CONV_CYC(CONV_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .go_i(conv_go), .clr_i(conv_clr),
    .busy_o(conv_busy), .done_o(conv_done)
  );
endmodule

// File: rtl/adc_rdbk_chk.sv
module adc_rdbk_chk #(
  parameter int unsigned CONV_CYC = 14000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sda_oe_o,
  input logic        stop_det,
  input logic        conv_go,
  input logic        conv_busy,
  input logic        conv_done,
  input logic        rd_ok,
  input logic [3:0]  ptr_ch,
  input logic [15:0] result
);
  int unsigned run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= 0;
    else if (conv_go) run_cnt <= 0;
    else if (conv_busy) run_cnt <= run_cnt + 1;
  end

  AST_BUS_FREE_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o); // R8
  AST_GO_STARTS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_go |=> conv_busy); // R4
  AST_CONV_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done |-> run_cnt == CONV_CYC - 1); // R4
  AST_NO_READY_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_busy && rd_ok)); // R5
  AST_TAG_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_ok) |-> result[14:11] == ptr_ch); // R6
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok && $past(rd_ok) |-> $stable(result)); // R7
endmodule

bind adc_rdbk_resp adc_rdbk_chk #(.CONV_CYC(CONV_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o), .stop_det(stop_det),
  .conv_go(conv_go), .conv_busy(conv_busy), .conv_done(conv_done),
  .rd_ok(rd_ok), .ptr_ch(ptr_ch), .result(result)
);

// File: tb/sim_adc_rdbk_resp.sv
`timescale 1ns/1ps
module sim_adc_rdbk_resp;
  localparam int CONV_US = 10;
  localparam int CONV = 200 * CONV_US;
  localparam int H = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [6:0] base = 7'h53;
  logic [109:0] smp = '0;
  wire sda_line = m_sda & ~sda_oe;
  int total = 0, bad = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  adc_rdbk_resp #(.CLK_MHZ(200), .CONV_US(CONV_US)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .base_addr_i(base), .sample_i(smp)
  );

  function automatic logic [15:0] exp_word(input int ch, input logic [109:0] s);
    logic [9:0] v;
    v = s[ch*10 +: 10];
    return {1'b0, 4'(ch), 1'b0, v};
  endfunction

  function automatic logic [6:0] cmd_addr(input logic [6:0] b);
    return (b & 7'h07) | 7'h48;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wc(H); m_scl = 1; wc(H); m_scl = 0; wc(H/2);
  endtask

  task automatic bit_in(output logic v);
    m_sda = 1; wc(H); m_scl = 1; wc(H/2); v = sda_line; wc(H/2); m_scl = 0; wc(H/2);
  endtask

  task automatic start_c();
    m_sda = 1; wc(H); m_scl = 1; wc(H); m_sda = 0; wc(H); m_scl = 0; wc(H/2);
  endtask

  task automatic stop_c();
    m_sda = 0; wc(H); m_scl = 1; wc(H); m_sda = 1; wc(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    logic v;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(v);
    ack = !v;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v);
      b[i] = v;
    end
    bit_out(!mack);
  endtask

  task automatic arm(input logic [6:0] a, input logic [7:0] p,
                     output bit aa, output bit pa, output bit ra);
    start_c(); wr_byte({a, 1'b0}, aa); wr_byte(p, pa);
    start_c(); wr_byte({a, 1'b1}, ra); stop_c();
  endtask

  task automatic read_word(input logic [6:0] a, output bit ack, output logic [15:0] w);
    logic [7:0] hi, lo;
    w = '0;
    start_c(); wr_byte({a, 1'b1}, ack);
    if (ack) begin
      rd_byte(1, hi); rd_byte(1, lo); w = {hi, lo};
    end
    stop_c();
  endtask

  task automatic rand_smp();
    for (int i = 0; i < 11; i++) smp[i*10 +: 10] = 10'($urandom);
  endtask

  task automatic full_read(input int ch, input string tag);
    bit aa, pa, ra, ack;
    logic [15:0] w, e;
    rand_smp();
    arm(cmd_addr(base), 8'(ch << 3), aa, pa, ra);
    chk(aa && pa, "R2", {aa, pa}, 3);
    chk(!ra, "R4", ra, 0);
    read_word(cmd_addr(base), ack, w);
    chk(!ack, "R5", ack, 0);
    wc(CONV);
    e = exp_word(ch, smp);
    read_word(cmd_addr(base), ack, w);
    chk(ack, "R5", ack, 1);
    chk(w == e, tag, w, e);
    chk(!sda_oe, "R8", sda_oe, 0);
    rand_smp();
    read_word(cmd_addr(base), ack, w);
    chk(ack && w == e, "R7", w, e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit aa, pa, ra, ack;
    logic [15:0] w;
    void'($urandom(32'd1357));
    wc(4);
    chk(!sda_oe, "R8", sda_oe, 0);
    rst_n = 1; wc(10);
    chk(!sda_oe, "R8", sda_oe, 0);

    // R1: foreign address
    start_c(); wr_byte({7'h4C, 1'b0}, ack); stop_c();
    chk(!ack, "R1", ack, 0);

    // R3: out of range then misaligned pointer
    arm(cmd_addr(base), 8'h58, aa, pa, ra);
    chk(pa && !ra, "R3", {pa, ra}, 2);
    wc(CONV + 100);
    read_word(cmd_addr(base), ack, w);
    chk(!ack, "R3", ack, 0);
    arm(cmd_addr(base), 8'h09, aa, pa, ra);
    wc(CONV + 100);
    read_word(cmd_addr(base), ack, w);
    chk(!ack, "R3", ack, 0);

    full_read(0, "R6");
    full_read(10, "R6");
    for (int k = 0; k < 5; k++) full_read(int'($urandom % 11), "R6");

    // R7: new pointer write discards result
    start_c(); wr_byte({cmd_addr(base), 1'b0}, aa); wr_byte(8'h18, pa); stop_c();
    read_word(cmd_addr(base), ack, w);
    chk(!ack, "R7", ack, 0);
    wc(CONV + 100);
    read_word(cmd_addr(base), ack, w);
    chk(ack && w == exp_word(3, smp), "R7", w, exp_word(3, smp));

    // R9: extra byte after pointer
    start_c(); wr_byte({cmd_addr(base), 1'b0}, aa); wr_byte(8'h20, pa);
    wr_byte(8'h00, ack); stop_c();
    chk(pa && !ack, "R9", {pa, ack}, 2);

    // R1: base change
    base = 7'h17;
    start_c(); wr_byte({7'h4B, 1'b0}, ack); stop_c();
    chk(!ack, "R1", ack, 0);
    full_read(10, "R1");

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule